// File: doc/BRIEF.md
# Multi-Mode UART Bit-Timing Generator

This block makes the bit timing for a 16550-style serial port that has an extra high-speed mode. It takes the UART reference clock and a small register interface, and it produces two strobes. The first is a transmit bit-boundary tick. The second is a receive sample strobe that lines up with the start bit of an incoming frame. The shifters, FIFOs, interrupts and framing logic sit elsewhere and use these two strobes. Of the line-control register, only the divisor-access bit is kept here.

One bit period is built from a divisor and a sub-tick count. A prescaler counts `divisor` reference clocks to make one sub-tick. A sub-tick counter then counts sub-ticks to make one bit. The mode register selects how many sub-ticks make a bit: sixteen, four, or a programmed count plus one. In the programmed mode, the receive sample index inside the bit is also set by a register. In the fixed modes the sample falls in the middle of the bit.

A new divisor, mode, count or sample point is not applied at once. It is copied into the working configuration at the next transmit bit boundary, or right away while the working divisor is zero. A falling edge on the synchronised receive line while no frame is in progress restarts the receive prescaler and sub-tick counter. It also opens a frame window of a fixed number of bit periods. Further edges inside that window are ignored.

Top module: `uart_bit_timing`

## Requirements
- R1: After reset the registers read as follows. Mode (byte address 0x24) reads 0. Sample count (0x28) reads 0x00. Sample point (0x2C) reads 0xFF. Rate-fix (0x34) reads 0. Line control (0x0C, bit 7 = divisor access) reads 0. The divisor reads 0. Registers sit at 4 × index, and an address with bits [1:0] not zero selects nothing.
- R2: The divisor low byte (0x00) and high byte (0x04) are written and read only while line-control bit 7 is 1. With that bit at 0, a write to 0x00 or 0x04 leaves the divisor unchanged, and a read returns 0.
- R3: In mode 0 or mode 1 (mode register bits [1:0]), `tx_tick` pulses for one clock every 16 × divisor clocks.
- R4: In mode 2, `tx_tick` pulses every 4 × divisor clocks.
- R5: In mode 3, `tx_tick` pulses every divisor × (sample count + 1) clocks, including a sample count of 0.
- R6: While the working divisor is 0, neither `tx_tick` nor `rx_sample` pulses.
- R7: A write to the divisor or the mode made part way through a bit does not change that bit. The new setting applies from the next `tx_tick` on.
- R8: In mode 0 the receive sample index is 8, and in mode 2 it is 2. The first `rx_sample` of a frame is seen (index + 1) × divisor + 2 clock edges after the first edge at which `rx_in` is low. This count includes the two-stage input synchroniser.
- R9: In mode 3 the sample index is the sample-point register. If that value is greater than the sample count, no `rx_sample` occurs.
- R10: A frame window lasts 10 receive bit periods. A falling edge on `rx_in` inside the window does not restart the receive timing, so the sample strobes stay exactly one bit period apart.
- R11: The rate-fix register (bit 0) is stored and can be read back. Its value has no effect on bit timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | UART reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` (combinational) |
| rx_in | input | 1 | Asynchronous receive line, idle high |
| tx_tick | output | 1 | One-clock pulse at each transmit bit boundary |
| rx_sample | output | 1 | One-clock pulse at the receive sample point inside a frame |

## Verification
A fault in the prescaler or the sub-tick counter shows up at the ports as a wrong `tx_tick` spacing. This is seen within one bit period, so the bench measures the distance from tick to tick in every mode. A fault in the working-configuration latch shows up as a bit that changes length before its boundary. It is caught on the first tick after a write made in the middle of a bit. A fault in the receive alignment or the frame window makes the first sample land at the wrong offset after the start edge, or makes a glitch inside the frame move the next sample. Both are visible within one bit of the edge.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
  localparam int REG_W = 8;

  localparam logic [3:0] IDX_DIV_LO = 4'd0;
  localparam logic [3:0] IDX_DIV_HI = 4'd1;
  localparam logic [3:0] IDX_LINE   = 4'd3;
  localparam logic [3:0] IDX_MODE   = 4'd9;
  localparam logic [3:0] IDX_SCOUNT = 4'd10;
  localparam logic [3:0] IDX_SPOINT = 4'd11;
  localparam logic [3:0] IDX_RFIX   = 4'd13;

  typedef enum logic [1:0] {
    HS_X16     = 2'd0,
    HS_X16_ALT = 2'd1,
    HS_X4      = 2'd2,
    HS_PROG    = 2'd3
  } hs_mode_e;

  // index of the last sub-tick in one bit
  function automatic logic [REG_W-1:0] last_sub(hs_mode_e m, logic [REG_W-1:0] cnt);
    case (m)
      HS_X4:   last_sub = 8'd3;
      HS_PROG: last_sub = cnt;
      default: last_sub = 8'd15;
    endcase
  endfunction

  // sub-tick on which the receiver samples
  function automatic logic [REG_W-1:0] mid_sub(hs_mode_e m, logic [REG_W-1:0] pt);
    case (m)
      HS_X4:   mid_sub = 8'd2;
      HS_PROG: mid_sub = pt;
      default: mid_sub = 8'd8;
    endcase
  endfunction
endpackage

// File: rtl/ubg_regs.sv
module ubg_regs
  import ubg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              bit_end,
  output logic [DIV_W-1:0]  act_div,
  output hs_mode_e          act_mode,
  output logic [REG_W-1:0]  act_cnt,
  output logic [REG_W-1:0]  act_pt
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             lane_ok;
  logic [REG_W-1:0] dlo_q, dlo_d, dhi_q, dhi_d, cnt_q, cnt_d, pt_q, pt_d;
  logic             dlab_q, dlab_d, rfix_q, rfix_d;
  hs_mode_e         mode_q, mode_d;
  logic [DIV_W-1:0] adiv_q, adiv_d;
  hs_mode_e         amode_q, amode_d;
  logic [REG_W-1:0] acnt_q, acnt_d, apt_q, apt_d;
  logic             load_cfg;

  assign idx     = addr[ADDR_W-1:2];
  assign lane_ok = (addr[1:0] == 2'b00);

  always_comb begin
    dlo_d = dlo_q; dhi_d = dhi_q; cnt_d = cnt_q; pt_d = pt_q;
    dlab_d = dlab_q; rfix_d = rfix_q; mode_d = mode_q;
    if (wr_en && lane_ok) begin
      case (idx)
        IDX_W'(IDX_DIV_LO): if (dlab_q) dlo_d = wdata;
        IDX_W'(IDX_DIV_HI): if (dlab_q) dhi_d = wdata;
        IDX_W'(IDX_LINE):   dlab_d = wdata[7];
        IDX_W'(IDX_MODE):   mode_d = hs_mode_e'(wdata[1:0]);
        IDX_W'(IDX_SCOUNT): cnt_d  = wdata;
        IDX_W'(IDX_SPOINT): pt_d   = wdata;
        IDX_W'(IDX_RFIX):   rfix_d = wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (lane_ok) begin
      case (idx)
        IDX_W'(IDX_DIV_LO): rdata = dlab_q ? dlo_q : '0;
        IDX_W'(IDX_DIV_HI): rdata = dlab_q ? dhi_q : '0;
        IDX_W'(IDX_LINE):   rdata = {dlab_q, 7'b0};
        IDX_W'(IDX_MODE):   rdata = {6'b0, mode_q};
        IDX_W'(IDX_SCOUNT): rdata = cnt_q;
        IDX_W'(IDX_SPOINT): rdata = pt_q;
        IDX_W'(IDX_RFIX):   rdata = {7'b0, rfix_q};
        default:            rdata = '0;
      endcase
    end
  end

  // working configuration: copied at a bit boundary or while stopped
  assign load_cfg = bit_end || (adiv_q == '0);

  always_comb begin
    adiv_d = adiv_q; amode_d = amode_q; acnt_d = acnt_q; apt_d = apt_q;
    if (load_cfg) begin
      adiv_d  = DIV_W'({dhi_q, dlo_q});
      amode_d = mode_q;
      acnt_d  = cnt_q;
      apt_d   = pt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlo_q <= '0; dhi_q <= '0; cnt_q <= 8'h00; pt_q <= 8'hff;
      dlab_q <= 1'b0; rfix_q <= 1'b0; mode_q <= HS_X16;
      adiv_q <= '0; amode_q <= HS_X16; acnt_q <= 8'h00; apt_q <= 8'hff;
    end else begin
      dlo_q <= dlo_d; dhi_q <= dhi_d; cnt_q <= cnt_d; pt_q <= pt_d;
      dlab_q <= dlab_d; rfix_q <= rfix_d; mode_q <= mode_d;
      adiv_q <= adiv_d; amode_q <= amode_d; acnt_q <= acnt_d; apt_q <= apt_d;
    end
  end

  assign act_div  = adiv_q;
  assign act_mode = amode_q;
  assign act_cnt  = acnt_q;
  assign act_pt   = apt_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_end && adiv_q != '0) |=> $stable(adiv_q) && $stable(amode_q)) else $error("cfg changed mid-bit"); // R7
endmodule

// File: rtl/ubg_bit_timer.sv
module ubg_bit_timer #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] last,
  input  logic [CNT_W-1:0] match_idx,
  output logic             bit_end,
  output logic             hit
);
  logic [DIV_W-1:0] pc_q, pc_d;
  logic [CNT_W-1:0] sc_q, sc_d;
  logic             stop, sub_en;

  always_comb begin
    stop    = (div == '0);
    sub_en  = !stop && (pc_q >= div - 1'b1);
    bit_end = sub_en && (sc_q >= last);
    hit     = sub_en && (sc_q == match_idx);
    pc_d    = pc_q;
    sc_d    = sc_q;
    if (stop || restart) begin
      pc_d = '0;
      sc_d = '0;
    end else if (sub_en) begin
      pc_d = '0;
      sc_d = bit_end ? '0 : sc_q + 1'b1;
    end else begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sc_q <= '0;
    end else begin
      pc_q <= pc_d;
      sc_q <= sc_d;
    end
  end

  AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> (sc_q == '0) && (pc_q == '0)) else $error("bit end did not wrap"); // R5
endmodule

// File: rtl/ubg_rx_align.sv
module ubg_rx_align #(
  parameter int FRAME_BITS  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic rx_bit_end,
  output logic start,
  output logic busy
);
  localparam int FB_W = $clog2(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   busy_q, busy_d;
  logic [FB_W-1:0]        nb_q, nb_d;
  logic                   fall;

  assign fall  = prev_q && !sync_q[SYNC_STAGES-1];
  assign start = fall && !busy_q;

  always_comb begin
    busy_d = busy_q;
    nb_d   = nb_q;
    if (start) begin
      busy_d = 1'b1;
      nb_d   = '0;
    end else if (busy_q && rx_bit_end) begin
      if (nb_q == FB_W'(FRAME_BITS - 1)) begin
        busy_d = 1'b0;
        nb_d   = '0;
      end else begin
        nb_d = nb_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      busy_q <= 1'b0;
      nb_q   <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
      prev_q <= sync_q[SYNC_STAGES-1];
      busy_q <= busy_d;
      nb_q   <= nb_d;
    end
  end

  assign busy = busy_q;

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q && (nb_q == '0)) else $error("start edge lost"); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rx_bit_end) |=> busy_q) else $error("frame window dropped early"); // R10
endmodule

// File: rtl/uart_bit_timing.sv
module uart_bit_timing
  import ubg_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DIV_W      = 16,
  parameter int FRAME_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              rx_in,
  output logic              tx_tick,
  output logic              rx_sample
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [DIV_W-1:0] act_div;
  hs_mode_e         act_mode;
  logic [REG_W-1:0] act_cnt, act_pt, last_idx, samp_idx;
  logic             tx_end, tx_first, rx_end, rx_hit, rx_start, rx_busy;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  ubg_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .bit_end(tx_end), .act_div(act_div), .act_mode(act_mode),
    .act_cnt(act_cnt), .act_pt(act_pt)
  );

  assign last_idx = last_sub(act_mode, act_cnt);
  assign samp_idx = mid_sub(act_mode, act_pt);

  ubg_bit_timer #(.DIV_W(DIV_W), .CNT_W(REG_W)) u_tx_timer (
    .clk(clk), .rst_n(rst_int_n), .restart(1'b0), .div(act_div),
    .last(last_idx), .match_idx('0), .bit_end(tx_end), .hit(tx_first)
  );

  ubg_bit_timer #(.DIV_W(DIV_W), .CNT_W(REG_W)) u_rx_timer (
    .clk(clk), .rst_n(rst_int_n), .restart(rx_start), .div(act_div),
    .last(last_idx), .match_idx(samp_idx), .bit_end(rx_end), .hit(rx_hit)
  );

  ubg_rx_align #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(2)) u_rx_align (
    .clk(clk), .rst_n(rst_int_n), .rx_in(rx_in), .rx_bit_end(rx_end),
    .start(rx_start), .busy(rx_busy)
  );

  assign tx_tick   = tx_end;
  assign rx_sample = rx_hit && rx_busy;

  AST_NO_TICK_DIV0: assert property (@(posedge clk) disable iff (!rst_int_n)
    (act_div == '0) |-> (!tx_tick && !rx_sample)) else $error("tick with zero divisor"); // R6
  AST_TX_FIRST_SUB: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_first && last_idx != '0) |-> !tx_tick) else $error("bit ended on first sub-tick"); // R3
endmodule

// File: tb/test_uart_bit_timing.sv
module test_uart_bit_timing;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [5:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       rx_in;
  logic       tx_tick;
  logic       rx_sample;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  uart_bit_timing i_uart_bit_timing (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rx_in(rx_in), .tx_tick(tx_tick), .rx_sample(rx_sample)
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 6'h3c;
  endtask

  task automatic rd(logic [5:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdata);
    addr = 6'h3c;
  endtask

  task automatic set_div(int d);
    wr(6'h0c, 8'h80);
    wr(6'h04, 8'(d >> 8));
    wr(6'h00, 8'(d));
    wr(6'h0c, 8'h00);
  endtask

  task automatic wait_tick(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (tx_tick) begin ok = 1'b1; break; end
    end
  endtask

  task automatic period(output int p);
    bit ok;
    p = -1;
    wait_tick(ok); wait_tick(ok); wait_tick(ok);
    if (ok) begin
      p = 0;
      for (int i = 0; i < 5000; i++) begin
        @(negedge clk); p++;
        if (tx_tick) break;
      end
    end
  endtask

  task automatic rx_latency(output int n);
    @(negedge clk);
    rx_in = 1'b0;
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); n++;
      if (rx_sample) break;
    end
    rx_in = 1'b1;
  endtask

  task automatic idle(int cycles);
    for (int i = 0; i < cycles; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    int v;
    rd(6'h24, v); check("R1 mode reset", v, 0);
    rd(6'h28, v); check("R1 count reset", v, 8'h00);
    rd(6'h2c, v); check("R1 point reset", v, 8'hff);
    rd(6'h34, v); check("R1 ratefix reset", v, 0);
    rd(6'h0c, v); check("R1 line reset", v, 0);
    check("R1 tick low", int'(tx_tick), 0);
  endtask

  task automatic t_dlab;
    int v, ticks;
    wr(6'h00, 8'h05);
    wr(6'h2b, 8'h33);
    rd(6'h2c, v); check("R1 misaligned write ignored", v, 8'hff);
    rd(6'h00, v); check("R2 read with access bit clear", v, 0);
    wr(6'h0c, 8'h80);
    rd(6'h00, v); check("R2 divisor untouched", v, 0);
    wr(6'h0c, 8'h00);
    ticks = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_tick || rx_sample) ticks++;
    end
    check("R6 no ticks with divisor 0", ticks, 0);
  endtask

  task automatic t_periods;
    int p, v;
    wr(6'h24, 8'h00); set_div(3);
    wr(6'h0c, 8'h80); rd(6'h00, v); wr(6'h0c, 8'h00);
    check("R2 divisor readback", v, 3);
    period(p); check("R3 mode0 div3", p, 48);
    wr(6'h24, 8'h01); set_div(1);
    period(p); check("R3 mode1 div1", p, 16);
    wr(6'h24, 8'h02); set_div(5);
    period(p); check("R4 mode2 div5", p, 20);
    wr(6'h28, 8'd7); wr(6'h24, 8'h03); set_div(2);
    period(p); check("R5 mode3 div2 cnt7", p, 16);
    wr(6'h28, 8'd0); set_div(3);
    period(p); check("R5 mode3 div3 cnt0", p, 3);
  endtask

  task automatic t_ratefix;
    int p, v;
    wr(6'h24, 8'h00); set_div(1);
    wr(6'h34, 8'h01);
    rd(6'h34, v); check("R11 ratefix readback", v, 1);
    period(p); check("R11 ratefix no effect", p, 16);
    wr(6'h34, 8'h00);
  endtask

  task automatic t_boundary;
    int p, n;
    bit ok;
    wr(6'h24, 8'h00); set_div(2);
    period(p); check("R7 mode0 div2 settled", p, 32);
    wait_tick(ok);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); n++;
      if (n == 5) begin wr_en = 1'b1; addr = 6'h24; wdata = 8'h02; end
      if (n == 6) begin wr_en = 1'b0; addr = 6'h3c; end
      if (tx_tick) break;
    end
    check("R7 current bit keeps old length", n, 32);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); n++;
      if (tx_tick) break;
    end
    check("R7 next bit uses new mode", n, 8);
  endtask

  task automatic t_rx_modes;
    int n, p;
    wr(6'h24, 8'h00); set_div(2); period(p);
    rx_latency(n); check("R8 mode0 sample offset", n, 20);
    idle(400);
    wr(6'h24, 8'h02); set_div(3); period(p);
    rx_latency(n); check("R8 mode2 sample offset", n, 11);
    idle(200);
    wr(6'h28, 8'd9); wr(6'h2c, 8'd4); wr(6'h24, 8'h03); set_div(2); period(p);
    check("R5 mode3 div2 cnt9", p, 20);
    rx_latency(n); check("R9 mode3 sample point", n, 12);
    idle(300);
  endtask

  task automatic t_rx_far_point;
    int hits, p;
    wr(6'h28, 8'd3); wr(6'h2c, 8'd9); set_div(1); period(p);
    @(negedge clk); rx_in = 1'b0;
    hits = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rx_sample) hits++;
    end
    rx_in = 1'b1;
    check("R9 point beyond count never samples", hits, 0);
    idle(60);
  endtask

  task automatic t_rx_ignore;
    int n, p;
    wr(6'h2c, 8'hff); wr(6'h28, 8'h00); wr(6'h24, 8'h00); set_div(1); period(p);
    rx_latency(n); check("R8 mode0 div1 offset", n, 11);
    rx_in = 1'b0;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); n++;
      if (n == 2) rx_in = 1'b1;
      if (n == 4) rx_in = 1'b0;
      if (rx_sample) break;
    end
    rx_in = 1'b1;
    check("R10 edge in frame ignored", n, 16);
    idle(200);
  endtask

  task automatic t_stop;
    int ticks;
    bit ok;
    set_div(0);
    wait_tick(ok);
    ticks = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tx_tick) ticks++;
    end
    check("R6 divisor 0 stops ticks", ticks, 0);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 6'h3c; wdata = 8'h00; rx_in = 1'b1;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_dlab;
    t_periods;
    t_ratefix;
    t_boundary;
    t_rx_modes;
    t_rx_far_point;
    t_rx_ignore;
    t_stop;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule